// File: doc/BRIEF.md
# Stopwatch Digit Snapshot Buffer With Lap Capture

This block sits between a multi-digit BCD stopwatch counter and a register-read path. Software reads the digits one register at a time, lowest first. A carry in the counter can fall between two of those reads, so the block keeps a snapshot that stays consistent across the whole sequence. A read of the lowest digit copies every live digit into a buffer at once and enters a held state. Reads of the middle and top digits then return buffered values. A read of the top digit closes the sequence and drops the hold.

An external lap pulse loads the same buffer from the live count and holds it until the top digit is read. If a lap arrives while a sequence is still open, the buffer is overwritten at once and the digits not yet read become stale. The next top-digit read then keeps the hold and raises a renewal flag, which tells software to start again from the lowest digit. Digit count and digit width are parameters. The defaults give three 4-bit digits: select 0 is thousandths, select 1 is hundredths and select 2 is tenths.

Top module: `lapcap_buf`

## Requirements
- R1: After reset, rd_data is 0, renew_flag is 0, the hold is clear and the buffer is zero.
- R2: A read with select 0 copies all live digits into the buffer in the same cycle and enters the hold. The returned value is the live digit 0.
- R3: While held, reads with select 1 or 2 return the buffered digit, even if the live count has changed.
- R4: A top-digit read (select 2) with no pending overwrite releases the hold. Later middle or top reads return live digits.
- R5: A read with select 1 or 2 while nothing is held returns the live digit and leaves the hold state unchanged.
- R6: A lap pulse loads the buffer from the live count and enters the hold. The hold lasts until a top-digit read.
- R7: A lap pulse while held marks the buffer as renewed. The next top-digit read keeps the hold and sets renew_flag to 1.
- R8: renew_flag is rewritten on every top-digit read and changes at no other time. It reads 0 when no overwrite has happened since the previous top-digit read.
- R9: A select-0 read after a blocked release re-latches the live count and clears the pending renewal. A later top-digit read then releases normally.
- R10: A lap pulse and a select-0 read in the same cycle load the lap snapshot and count as a renewal.
- R11: A read with a select of DIGITS or above returns 0 and changes no state.
- R12: rd_data is registered. It shows the result of a strobe one clock after that strobe and keeps its value while there is no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| live_cnt | input | DIGITS*DIG_W | Live BCD count, digit 0 in the low bits |
| rd_stb | input | 1 | Read strobe, one cycle per register read |
| rd_sel | input | SEL_W | Digit select for the read |
| lap_pulse | input | 1 | Lap capture request, one cycle |
| rd_data | output | DIG_W | Registered read data |
| renew_flag | output | 1 | Buffer renewed during the last read sequence |

## Verification
Every result is due one clock after its stimulus. A strobe or lap driven before a rising edge shows up on rd_data and renew_flag after that edge. The hold and renewal state only becomes visible through later reads. The bench therefore drives inputs on the falling edge and runs a reference model across the next rising edge. It compares both outputs at the following falling edge on every cycle, including idle cycles, so hold, release and flag effects are checked on the read that exposes them.

// File: rtl/snap_pkg.sv
package snap_pkg;
   // Classified read request for the current cycle
   typedef enum logic [2:0] {
      RK_IDLE = 3'd0,
      RK_LOW  = 3'd1,
      RK_MID  = 3'd2,
      RK_TOP  = 3'd3,
      RK_BAD  = 3'd4
   } rd_kind_e;
endpackage

// File: rtl/snap_store.sv
module snap_store #(
   parameter int DIGITS = 3,
   parameter int DIG_W  = 4,
   localparam int TOT_W = DIGITS * DIG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [TOT_W-1:0] live_i,
   output logic [TOT_W-1:0] buf_o
);
   // one register per digit, all loaded by the same strobe
   for (genvar g = 0; g < DIGITS; g++) begin : g_dig
      logic [DIG_W-1:0] dig_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      dig_q <= '0;
         else if (load_i) dig_q <= live_i[g*DIG_W +: DIG_W];
      end
      assign buf_o[g*DIG_W +: DIG_W] = dig_q;
   end

   // R2
   store_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> buf_o == $past(live_i));
   // R3
   store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(buf_o));
endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
   import snap_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     lap_i,
   input  rd_kind_e kind_i,
   output logic     load_o,
   output logic     held_o,
   output logic     renew_o
);
   logic held_q, held_d;
   logic pend_q, pend_d;
   logic flag_q, flag_d;

   always_comb begin
      held_d = held_q;
      pend_d = pend_q;
      flag_d = flag_q;
      load_o = 1'b0;
      if (lap_i) begin
         load_o = 1'b1;
         held_d = 1'b1;
         pend_d = held_q || (kind_i == RK_LOW);
         if (kind_i == RK_TOP) flag_d = pend_q;
      end else begin
         unique case (kind_i)
            RK_LOW: begin
               load_o = 1'b1;
               held_d = 1'b1;
               pend_d = 1'b0;
            end
            RK_TOP: begin
               flag_d = pend_q;
               held_d = held_q && pend_q;
               pend_d = 1'b0;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         pend_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         held_q <= held_d;
         pend_q <= pend_d;
         flag_q <= flag_d;
      end
   end

   assign held_o  = held_q;
   assign renew_o = flag_q;

   // R2
   low_enters_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == RK_LOW) |=> held_o);
   // R4
   clean_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == RK_TOP && !lap_i && !pend_q) |=> (!held_o && !renew_o));
   // R7
   blocked_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == RK_TOP && !lap_i && pend_q) |=> (held_o && renew_o));
   // R8
   flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i != RK_TOP) |=> $stable(renew_o));
   // R10
   lap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lap_i && kind_i == RK_LOW) |=> (pend_q && held_o));
endmodule

// File: rtl/snap_rdmux.sv
module snap_rdmux #(
   parameter int DIGITS = 3,
   parameter int DIG_W  = 4,
   parameter int SEL_W  = 2,
   localparam int TOT_W = DIGITS * DIG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stb,
   input  logic [SEL_W-1:0] rd_sel,
   input  logic             held_i,
   input  logic [TOT_W-1:0] live_i,
   input  logic [TOT_W-1:0] buf_i,
   output logic [DIG_W-1:0] rd_data
);
   logic [DIG_W-1:0] cand [DIGITS];
   logic [DIG_W-1:0] pick;
   logic [DIG_W-1:0] data_q;

   // digit 0 is latched on its own read, so the live value is the snapshot
   for (genvar g = 0; g < DIGITS; g++) begin : g_cand
      if (g == 0) begin : g_low
         assign cand[g] = live_i[DIG_W-1:0];
      end else begin : g_up
         assign cand[g] = held_i ? buf_i[g*DIG_W +: DIG_W]
                                 : live_i[g*DIG_W +: DIG_W];
      end
   end

   always_comb begin
      pick = '0;
      for (int i = 0; i < DIGITS; i++) begin
         if (rd_sel == SEL_W'(i)) pick = cand[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      data_q <= '0;
      else if (rd_stb) data_q <= pick;
   end

   assign rd_data = data_q;

   // R11
   bad_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && int'(rd_sel) >= DIGITS) |=> rd_data == '0);
   // R12
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rd_data));
   // R5
   live_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !held_i && int'(rd_sel) < DIGITS)
      |=> rd_data == $past(live_i[int'(rd_sel)*DIG_W +: DIG_W]));
endmodule

// File: rtl/lapcap_buf.sv
module lapcap_buf
   import snap_pkg::*;
#(
   parameter int DIGITS = 3,
   parameter int DIG_W  = 4,
   parameter int SEL_W  = $clog2(DIGITS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [DIGITS*DIG_W-1:0] live_cnt,
   input  logic                    rd_stb,
   input  logic [SEL_W-1:0]        rd_sel,
   input  logic                    lap_pulse,
   output logic [DIG_W-1:0]        rd_data,
   output logic                    renew_flag
);
   localparam int TOT_W = DIGITS * DIG_W;

   if (DIGITS < 2) begin : g_bad_digits
      $error("lapcap_buf: DIGITS must be at least 2");
   end
   if (DIG_W < 1) begin : g_bad_width
      $error("lapcap_buf: DIG_W must be at least 1");
   end
   if (SEL_W < $clog2(DIGITS)) begin : g_bad_sel
      $error("lapcap_buf: SEL_W too narrow for DIGITS");
   end

   rd_kind_e         kind;
   logic             load;
   logic             held;
   logic [TOT_W-1:0] snap;

   always_comb begin
      if (!rd_stb)                             kind = RK_IDLE;
      else if (rd_sel == '0)                   kind = RK_LOW;
      else if (rd_sel == SEL_W'(DIGITS - 1))   kind = RK_TOP;
      else if (int'(rd_sel) < DIGITS)          kind = RK_MID;
      else                                     kind = RK_BAD;
   end

   snap_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .lap_i   (lap_pulse),
      .kind_i  (kind),
      .load_o  (load),
      .held_o  (held),
      .renew_o (renew_flag)
   );

   snap_store #(.DIGITS(DIGITS), .DIG_W(DIG_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .live_i (live_cnt),
      .buf_o  (snap)
   );

   snap_rdmux #(.DIGITS(DIGITS), .DIG_W(DIG_W), .SEL_W(SEL_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_stb  (rd_stb),
      .rd_sel  (rd_sel),
      .held_i  (held),
      .live_i  (live_cnt),
      .buf_i   (snap),
      .rd_data (rd_data)
   );

   // R6
   lap_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lap_pulse |=> (held && snap == $past(live_cnt)));
   // R11
   bad_sel_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == RK_BAD && !lap_pulse) |=> ($stable(held) && $stable(snap) && $stable(renew_flag)));
endmodule

// File: tb/sim_lapcap_buf.sv
module sim_lapcap_buf;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] live = '0;
   logic        rd_stb = 1'b0;
   logic [1:0]  rd_sel = '0;
   logic        lap = 1'b0;
   wire  [3:0]  rd_data;
   wire         renew;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [11:0] m_buf  = '0;
   bit          m_held = 1'b0;
   bit          m_pend = 1'b0;
   bit          m_flag = 1'b0;
   logic [3:0]  m_rd   = '0;

   always #2.5 clk = ~clk;

   lapcap_buf u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .live_cnt   (live),
      .rd_stb     (rd_stb),
      .rd_sel     (rd_sel),
      .lap_pulse  (lap),
      .rd_data    (rd_data),
      .renew_flag (renew)
   );

   function automatic logic [3:0] dig(input logic [11:0] v, input int i);
      return v[i*4 +: 4];
   endfunction

   function automatic logic [11:0] rand_bcd();
      return {4'($urandom_range(9)), 4'($urandom_range(9)), 4'($urandom_range(9))};
   endfunction

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp_v,
                        input string what);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s: %s actual %h expected %h", tag, what, act, exp_v);
      end
   endtask

   // drive one cycle at a falling edge, update the model, check at the next falling edge
   task automatic step(input bit s, input logic [1:0] sel, input bit l,
                       input logic [11:0] lv, input string tag);
      bit rd0, rd2, np;
      live = lv; rd_stb = s; rd_sel = sel; lap = l;
      rd0 = s && sel == 2'd0;
      rd2 = s && sel == 2'd2;
      if (s) begin
         if (sel == 2'd0)     m_rd = dig(lv, 0);
         else if (sel < 2'd3) m_rd = m_held ? dig(m_buf, int'(sel)) : dig(lv, int'(sel));
         else                 m_rd = 4'h0;
      end
      if (l) begin
         np = m_held || rd0;
         if (rd2) m_flag = m_pend;
         m_buf = lv; m_held = 1'b1; m_pend = np;
      end else if (rd0) begin
         m_buf = lv; m_held = 1'b1; m_pend = 1'b0;
      end else if (rd2) begin
         m_flag = m_pend;
         if (!m_pend) m_held = 1'b0;
         m_pend = 1'b0;
      end
      @(negedge clk);
      check(tag, rd_data, m_rd, "rd_data");
      check(tag, {3'b0, renew}, {3'b0, m_flag}, "renew_flag");
      rd_stb = 1'b0; lap = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1729));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1", rd_data, 4'h0, "rd_data after reset");
      check("R1", {3'b0, renew}, 4'h0, "renew_flag after reset");
      step(1, 2'd1, 0, 12'h482, "R1_R5");           // not held: live hundredths
      step(1, 2'd2, 0, 12'h482, "R5");              // not held: live tenths
      // R2 R3 R4: ordered sequence with changing count
      step(1, 2'd0, 0, 12'h123, "R2");
      step(0, 2'd0, 0, 12'h456, "R12");
      step(1, 2'd1, 0, 12'h456, "R3");
      step(1, 2'd2, 0, 12'h460, "R3_R8");
      step(1, 2'd1, 0, 12'h789, "R4");
      // R6 lap snapshot
      step(0, 2'd0, 1, 12'h321, "R6_R12");
      step(1, 2'd1, 0, 12'h999, "R6");
      step(1, 2'd2, 0, 12'h999, "R6");
      step(1, 2'd1, 0, 12'h950, "R4");
      // R7 R9 overwrite during a sequence
      step(1, 2'd0, 0, 12'h555, "R2");
      step(0, 2'd0, 1, 12'h642, "R7");
      step(1, 2'd1, 0, 12'h650, "R7");
      step(1, 2'd2, 0, 12'h650, "R7");
      step(1, 2'd1, 0, 12'h111, "R7");
      step(1, 2'd0, 0, 12'h777, "R9");
      step(1, 2'd2, 0, 12'h000, "R9_R8");
      step(1, 2'd1, 0, 12'h333, "R9");
      // R10 lap with lowest read in the same cycle
      step(1, 2'd0, 1, 12'h246, "R10");
      step(1, 2'd2, 0, 12'h300, "R10");
      // R11 out-of-range select
      step(1, 2'd3, 0, 12'h888, "R11");
      step(1, 2'd1, 0, 12'h888, "R11");
      step(1, 2'd3, 0, 12'h999, "R11");
      step(1, 2'd2, 0, 12'h999, "R11_R8");
      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         bit s, l;
         logic [1:0] sel;
         string tag;
         s   = ($urandom_range(3) != 0);
         l   = ($urandom_range(9) == 0);
         sel = 2'($urandom_range(3));
         if (l)               tag = "R6_R7_R10";
         else if (!s)         tag = "R12";
         else if (sel == 2'd0) tag = "R2";
         else if (sel == 2'd3) tag = "R11";
         else if (sel == 2'd2) tag = "R4_R8";
         else                 tag = "R3_R5";
         step(s, sel, l, rand_bcd(), tag);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule